// File: doc/BRIEF.md
# Ping-Pong Block Buffer Controller

This block owns two symbol banks that are used in turn: while one bank is filled with a new block of symbols, the bank filled before it is read back out. The input side starts a block on a first-data strobe, captures the block length and the first symbol in that same cycle, and then accepts one symbol per cycle in which the new-data qualifier is high. Two flags tell the source what it may send. One is ready for first data, which permits a new block to start. The other is ready for data, which permits further symbols to be sent.

The output side drains a full bank. It presents one linear read address per step on a port. It returns two words per step: the symbol stored at that linear address, and the symbol stored at an interleaved address that an external permutation function supplies through an input port. A downstream-ready input freezes the whole output side when it is low, and the input side keeps running while it is frozen. A clock enable holds every register. A synchronous clear, which only takes effect while the clock enable is high, returns the block to idle. The data word is one bit per channel, and all channels share the same control signals and the same block length.

Top module: `pingpong_buf_ctrl`

## Requirements
- R1: A block starts on an edge where ce is high, sclr is low, fdIn is high, nd is high (when USE_ND=1) and rffd is high. On that edge the block length on blkLen is captured, dataIn is written as symbol 0, and rffd is low after the edge whenever the length is greater than 1.
- R2: While a block is loading, an edge with nd low writes nothing and does not advance the write position. The symbols accepted on edges with nd high are stored in order as symbols 1 to L-1.
- R3: Once L symbols have been accepted, sampling stops. If the other bank is still waiting or draining at that point, both rfd and rffd are low in the cycle after the last accepted symbol.
- R4: rffd rises in the cycle after the other bank's last output step. If that bank is already empty when loading ends, rffd and rfd are both high in the very next cycle, with no gap.
- R5: Blocks are filled into bank 0 and bank 1 in turn, starting from bank 0 after a clear. They are drained in the order they were filled. With outReady held high and the drain side idle, outValid first rises L+1 cycles after the edge that started a block of length L.
- R6: Draining step i, for i from 0 to L-1, shows outLinAddr = i in the cycle before the step. The step returns rdDataLin = symbol i and rdDataIlv = the symbol at the index presented on ilvAddr during that cycle. outValid is high in the cycle after each step.
- R7: An edge with outReady low changes none of outValid, outLinAddr, rdDataLin or rdDataIlv, and the bank drain does not advance. Loading into the other bank still proceeds, with rfd high.
- R8: An edge with ce low changes no state. That edge ignores sclr, fdIn, nd and dataIn.
- R9: After rstN or after an edge with ce and sclr both high, rffd = 1, rfd = 1, outValid = 0, and both banks are empty. A partly loaded block is discarded.
- R10: lenValid is updated on every block start. It is 1 if the captured length lies from MIN_LEN up to min(MAX_LEN, DEPTH), and 0 otherwise. It is 0 after reset. With the defaults, the legal range is 40 to 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous power-up reset, active low |
| ce | input | 1 | Clock enable; low holds all state |
| sclr | input | 1 | Synchronous clear, qualified by ce |
| fdIn | input | 1 | First-data strobe |
| nd | input | 1 | New-data qualifier |
| blkLen | input | LEN_W | Block length, sampled on a block start |
| dataIn | input | CHANNELS | Input symbol, one bit per channel |
| rffd | output | 1 | Ready for first data |
| rfd | output | 1 | Ready for data |
| lenValid | output | 1 | Last captured length was in range |
| outReady | input | 1 | Downstream ready; low freezes the output side |
| outValid | output | 1 | Read data valid |
| outLinAddr | output | ADDR_W | Linear read index of the next drain step |
| ilvAddr | input | ADDR_W | Interleaved read index for the current step |
| rdDataLin | output | CHANNELS | Symbol at the linear index |
| rdDataIlv | output | CHANNELS | Symbol at the interleaved index |

## Verification
A wrong bank-full flag or a wrong bank pointer shows up at the ports within one block. The ready flags then rise early or late against the drain of the other bank, or a whole block comes out in the wrong order or with another block's symbols. A write position that miscounts, or that advances on a gap or a held edge, shifts the whole block. The shift is visible in the first or second symbol drained from that bank, both on the linear word and on the reversed interleaved word. A frozen output stage that leaks shows up in the very next cycle as a changed address or data word while downstream-ready is low.

// File: rtl/ppbuf_pkg.sv
package ppbuf_pkg;

  // Strobes the control hands to the datapath each cycle.
  typedef struct packed {
    logic wrEn;
    logic wrBank;
    logic rdEn;
    logic rdBank;
  } ppStrobes_t;

endpackage

// File: rtl/ppbuf_ctrl.sv
module ppbuf_ctrl
  import ppbuf_pkg::*;
#(
  parameter int LEN_W     = 13,
  parameter int ADDR_W    = 8,
  parameter int MIN_LEN   = 40,
  parameter int LEN_LIMIT = 256,
  parameter int USE_ND    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ce,
  input  logic              sclr,
  input  logic              fdIn,
  input  logic              nd,
  input  logic [LEN_W-1:0]  blkLen,
  input  logic              outReady,
  output ppStrobes_t        strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rffd,
  output logic              rfd,
  output logic              outValid,
  output logic              lenValid
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  // load side state
  logic             loading;
  logic [LEN_W-1:0] wrCnt;
  logic [LEN_W-1:0] loadLen;
  logic             wrBank;
  // shared bank state
  logic [1:0]            full;
  logic [1:0][LEN_W-1:0] bankLen;
  // drain side state
  logic             draining;
  logic [LEN_W-1:0] rdCnt;
  logic             rdBank;

  logic ndQ, rffdC, validFd, wrStep, lastWrFd, lastWr, loadDone;
  logic drainStart, drainStep, drainLast, lenInRange;

  always_comb begin
    ndQ        = (USE_ND != 0) ? nd : 1'b1;
    rffdC      = !loading && !full[wrBank];
    validFd    = fdIn && ndQ && rffdC;
    wrStep     = loading && ndQ;
    lastWrFd   = validFd && (blkLen <= ONE);
    lastWr     = wrStep && (wrCnt == loadLen - ONE);
    loadDone   = lastWrFd || lastWr;
    drainStart = !draining && full[rdBank] && outReady;
    drainStep  = draining && outReady;
    drainLast  = drainStep && (rdCnt == bankLen[rdBank] - ONE);
    lenInRange = (blkLen >= LEN_W'(MIN_LEN)) && (blkLen <= LEN_W'(LEN_LIMIT));
  end

  always_comb begin
    strb.wrEn   = ce && !sclr && (validFd || wrStep);
    strb.wrBank = wrBank;
    strb.rdEn   = ce && !sclr && drainStep;
    strb.rdBank = rdBank;
    wrAddr      = validFd ? '0 : wrCnt[ADDR_W-1:0];
    rdAddr      = rdCnt[ADDR_W-1:0];
    rffd        = rffdC;
    rfd         = loading || rffdC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loading  <= 1'b0;
      wrCnt    <= '0;
      loadLen  <= '0;
      wrBank   <= 1'b0;
      full     <= '0;
      bankLen  <= '0;
      draining <= 1'b0;
      rdCnt    <= '0;
      rdBank   <= 1'b0;
      outValid <= 1'b0;
      lenValid <= 1'b0;
    end else if (ce && sclr) begin
      loading  <= 1'b0;
      wrCnt    <= '0;
      loadLen  <= '0;
      wrBank   <= 1'b0;
      full     <= '0;
      bankLen  <= '0;
      draining <= 1'b0;
      rdCnt    <= '0;
      rdBank   <= 1'b0;
      outValid <= 1'b0;
      lenValid <= 1'b0;
    end else if (ce) begin
      // load side
      if (validFd) begin
        loadLen  <= blkLen;
        wrCnt    <= ONE;
        loading  <= !lastWrFd;
        lenValid <= lenInRange;
      end else if (wrStep) begin
        wrCnt <= wrCnt + ONE;
        if (lastWr) loading <= 1'b0;
      end
      if (loadDone) begin
        full[wrBank]    <= 1'b1;
        bankLen[wrBank] <= validFd ? blkLen : loadLen;
        wrBank          <= ~wrBank;
      end
      // drain side, frozen while downstream is not ready
      if (outReady) begin
        outValid <= draining;
        if (drainStart) begin
          draining <= 1'b1;
          rdCnt    <= '0;
        end else if (draining) begin
          if (drainLast) begin
            draining <= 1'b0;
            rdCnt    <= '0;
            rdBank   <= ~rdBank;
          end else begin
            rdCnt <= rdCnt + ONE;
          end
        end
      end
      if (drainLast) full[rdBank] <= 1'b0;
    end
  end

endmodule

// File: rtl/ppbuf_datapath.sv
module ppbuf_datapath
  import ppbuf_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int DEPTH    = 256,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  ppStrobes_t          strb,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [ADDR_W-1:0]   ilvAddr,
  input  logic [CHANNELS-1:0] dataIn,
  output logic [CHANNELS-1:0] rdDataLin,
  output logic [CHANNELS-1:0] rdDataIlv
);

  localparam int NBANK = 2;

  logic [NBANK-1:0][CHANNELS-1:0] linQ;
  logic [NBANK-1:0][CHANNELS-1:0] ilvQ;
  logic selQ;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [CHANNELS-1:0] mem [DEPTH];
    logic hitWr, hitRd;
    assign hitWr = strb.wrEn && (strb.wrBank == 1'(b));
    assign hitRd = strb.rdEn && (strb.rdBank == 1'(b));
    always_ff @(posedge clk) begin
      if (hitWr) mem[wrAddr] <= dataIn;
      if (hitRd) begin
        linQ[b] <= mem[rdAddr];
        ilvQ[b] <= mem[ilvAddr];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.rdEn) selQ <= strb.rdBank;
  end

  assign rdDataLin = linQ[selQ];
  assign rdDataIlv = ilvQ[selQ];

endmodule

// File: rtl/pingpong_buf_ctrl.sv
module pingpong_buf_ctrl
  import ppbuf_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int DEPTH    = 256,
  parameter int LEN_W    = 13,
  parameter int MIN_LEN  = 40,
  parameter int MAX_LEN  = 5114,
  parameter int USE_ND   = 1,
  localparam int ADDR_W    = $clog2(DEPTH),
  localparam int LEN_LIMIT = (MAX_LEN < DEPTH) ? MAX_LEN : DEPTH
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ce,
  input  logic                sclr,
  input  logic                fdIn,
  input  logic                nd,
  input  logic [LEN_W-1:0]    blkLen,
  input  logic [CHANNELS-1:0] dataIn,
  output logic                rffd,
  output logic                rfd,
  output logic                lenValid,
  input  logic                outReady,
  output logic                outValid,
  output logic [ADDR_W-1:0]   outLinAddr,
  input  logic [ADDR_W-1:0]   ilvAddr,
  output logic [CHANNELS-1:0] rdDataLin,
  output logic [CHANNELS-1:0] rdDataIlv
);

  ppStrobes_t        strb;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  ppbuf_ctrl #(
    .LEN_W(LEN_W), .ADDR_W(ADDR_W), .MIN_LEN(MIN_LEN),
    .LEN_LIMIT(LEN_LIMIT), .USE_ND(USE_ND)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ce(ce), .sclr(sclr), .fdIn(fdIn), .nd(nd),
    .blkLen(blkLen), .outReady(outReady), .strb(strb), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .rffd(rffd), .rfd(rfd), .outValid(outValid),
    .lenValid(lenValid)
  );

  ppbuf_datapath #(
    .CHANNELS(CHANNELS), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .ilvAddr(ilvAddr), .dataIn(dataIn), .rdDataLin(rdDataLin),
    .rdDataIlv(rdDataIlv)
  );

  assign outLinAddr = rdAddr;

endmodule

// File: rtl/ppbuf_checker.sv
module ppbuf_checker #(
  parameter int CHANNELS = 4,
  parameter int LEN_W    = 13,
  parameter int ADDR_W   = 8,
  parameter int USE_ND   = 1
) (
  input logic                clk,
  input logic                rstN,
  input logic                ce,
  input logic                sclr,
  input logic                fdIn,
  input logic                nd,
  input logic [LEN_W-1:0]    blkLen,
  input logic [CHANNELS-1:0] dataIn,
  input logic                rffd,
  input logic                rfd,
  input logic                lenValid,
  input logic                outReady,
  input logic                outValid,
  input logic [ADDR_W-1:0]   outLinAddr,
  input logic [ADDR_W-1:0]   ilvAddr,
  input logic [CHANNELS-1:0] rdDataLin,
  input logic [CHANNELS-1:0] rdDataIlv
);

  logic ndOk;
  assign ndOk = (USE_ND == 0) ? 1'b1 : nd;

  // R1: a block start takes the ready-for-first-data flag down
  a_r1_rffd_drops: assert property (@(posedge clk) disable iff (!rstN)
    (ce && !sclr && fdIn && ndOk && rffd && (blkLen > LEN_W'(1))) |=> !rffd);

  // R7: back-pressure freezes the output side
  a_r7_output_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (ce && !sclr && !outReady) |=> ($stable(outValid) && $stable(outLinAddr)));

  // R8: clock enable low holds every flag and the drain index
  a_r8_ce_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ce |=> ($stable(rffd) && $stable(rfd) && $stable(outValid)
             && $stable(outLinAddr) && $stable(lenValid)));

  // R9: clear returns to idle
  a_r9_clear_idle: assert property (@(posedge clk) disable iff (!rstN)
    (ce && sclr) |=> (rffd && rfd && !outValid));

  // R6: mid-block drain steps advance the linear index by one or wrap to zero
  a_r6_index_step: assert property (@(posedge clk) disable iff (!rstN)
    (ce && !sclr && outReady && outValid && (outLinAddr != '0))
      |=> ((outLinAddr == $past(outLinAddr) + ADDR_W'(1)) || (outLinAddr == '0)));

endmodule

bind pingpong_buf_ctrl ppbuf_checker #(
  .CHANNELS(CHANNELS), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .USE_ND(USE_ND)
) u_chk (.*);

// File: tb/tb_pingpong_buf_ctrl.sv
`timescale 1ns/1ps
module tb_pingpong_buf_ctrl;

  localparam int CH    = 4;
  localparam int DEPTH = 256;
  localparam int LW    = 13;
  localparam int AW    = $clog2(DEPTH);
  localparam int NB    = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ce = 1'b1, sclr = 1'b0, fdIn = 1'b0, nd = 1'b0, outReady = 1'b1;
  logic [LW-1:0] blkLen = '0;
  logic [CH-1:0] dataIn = '0;
  logic rffd, rfd, lenValid, outValid;
  logic [AW-1:0] outLinAddr, ilvAddr;
  logic [CH-1:0] rdDataLin, rdDataIlv;

  always #2.5 clk = ~clk;

  pingpong_buf_ctrl #(.CHANNELS(CH), .DEPTH(DEPTH), .LEN_W(LW)) dut (
    .clk(clk), .rstN(rstN), .ce(ce), .sclr(sclr), .fdIn(fdIn), .nd(nd),
    .blkLen(blkLen), .dataIn(dataIn), .rffd(rffd), .rfd(rfd),
    .lenValid(lenValid), .outReady(outReady), .outValid(outValid),
    .outLinAddr(outLinAddr), .ilvAddr(ilvAddr), .rdDataLin(rdDataLin),
    .rdDataIlv(rdDataIlv)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [CH-1:0] stim [NB][300];
  int stimLen [NB];
  int blkErr [NB];
  int nQueued = 0, rdBlk = 0, rdIdx = 0, blkDone = 0;
  int stableBad = 0;
  bit stallMode = 1'b0;

  // external permutation stub: reversal within the draining block
  assign ilvAddr = AW'(stimLen[rdBlk] - 1 - int'(outLinAddr));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic logic [CH-1:0] mkword(input int b, input int i);
    return CH'(((i * 13) + (b * 7) + ((i >> 4) * 5)) ^ (i >> 1));
  endfunction

  // output sink with optional stalls
  initial begin
    int stallCnt = 0;
    bit prevStall = 0;
    logic [CH-1:0] sLin, sIlv;
    logic [AW-1:0] sAddr;
    for (int k = 0; k < NB; k++) begin stimLen[k] = 1; blkErr[k] = 0; end
    forever begin
      bit stall;
      @(negedge clk);
      if (prevStall && (!outValid || rdDataLin !== sLin || rdDataIlv !== sIlv
                        || outLinAddr !== sAddr))
        stableBad++;
      stallCnt++;
      stall = stallMode && ((stallCnt % 3 == 1) || (stallCnt % 7 == 0));
      outReady = !stall;
      if (outValid && !stall && rdBlk < NB) begin
        if (rdDataLin !== stim[rdBlk][rdIdx]) blkErr[rdBlk]++;
        if (rdDataIlv !== stim[rdBlk][stimLen[rdBlk] - 1 - rdIdx]) blkErr[rdBlk]++;
        rdIdx++;
        if (rdIdx == stimLen[rdBlk]) begin
          rdIdx = 0; rdBlk++; blkDone++;
        end
      end
      prevStall = outValid && stall;
      sLin = rdDataLin; sIlv = rdDataIlv; sAddr = outLinAddr;
    end
  end

  task automatic load_block(input int len, input int gapEvery, input bit ceGap,
                            output int fdCycle, output bit rfdDrop);
    int b = nQueued;
    rfdDrop = 0;
    while (!rffd) @(negedge clk);
    stimLen[b] = len;
    for (int i = 0; i < len; i++) begin
      if (gapEvery > 0 && i > 0 && (i % gapEvery) == 0) begin
        fdIn = 0; nd = 0; dataIn = ~mkword(b, i);
        @(negedge clk);
      end
      if (ceGap && i == len / 2) begin
        logic hr, hd;
        hr = rffd; hd = rfd;
        ce = 0; sclr = 1; fdIn = 1; nd = 1; dataIn = ~mkword(b, i);
        repeat (4) @(negedge clk);
        chk(rffd == hr && rfd == hd && !outValid, "R8 flags held while ce low",
            int'({rffd, rfd, outValid}), int'({hr, hd, 1'b0}));
        ce = 1; sclr = 0; fdIn = 0;
      end
      if (i > 0 && !rfd) rfdDrop = 1;
      stim[b][i] = mkword(b, i);
      fdIn = (i == 0); nd = 1; blkLen = LW'(len); dataIn = stim[b][i];
      if (i == 0) fdCycle = cyc + 1;
      @(negedge clk);
    end
    fdIn = 0; nd = 0;
    nQueued++;
  endtask

  task automatic wait_drained(input int n);
    int t = 0;
    while (blkDone < n && t < 5000) begin @(negedge clk); t++; end
    chk(blkDone >= n, "R5 blocks drained", blkDone, n);
  endtask

  task automatic t_reset();
    chk(rffd && rfd && !outValid && !lenValid, "R9 reset state",
        int'({rffd, rfd, outValid, lenValid}), 4'b1100);
  endtask

  task automatic t_single();
    int fc, seen; bit dr;
    load_block(40, 0, 0, fc, dr);
    chk(rffd && rfd, "R4 no gap when other bank empty", int'({rffd, rfd}), 3);
    chk(lenValid, "R10 length 40 in range", int'(lenValid), 1);
    while (!outValid) @(negedge clk);
    seen = cyc;
    chk(seen - fc == 41, "R5 first valid latency", seen - fc, 41);
    wait_drained(nQueued);
    chk(blkErr[0] == 0, "R6 R1 single block content", blkErr[0], 0);
  endtask

  task automatic t_gaps();
    int fc; bit dr; int b = nQueued;
    load_block(50, 3, 0, fc, dr);
    wait_drained(nQueued);
    chk(blkErr[b] == 0, "R2 nd gaps ignored", blkErr[b], 0);
  endtask

  task automatic t_back_to_back();
    int fa, fb; bit dr; int b = nQueued;
    load_block(40, 0, 0, fa, dr);
    load_block(40, 0, 0, fb, dr);
    chk(fb - fa == 40, "R4 second start without gap", fb - fa, 40);
    chk(!rfd && !rffd, "R3 rfd and rffd low while other bank drains",
        int'({rfd, rffd}), 0);
    @(negedge clk);
    chk(rffd && rfd, "R4 rffd rises after drain ends", int'({rffd, rfd}), 3);
    wait_drained(nQueued);
    chk(blkErr[b] == 0 && blkErr[b+1] == 0, "R5 alternating order content",
        blkErr[b] + blkErr[b+1], 0);
  endtask

  task automatic t_backpressure();
    int fc; bit dr; int b = nQueued;
    stallMode = 1; stableBad = 0;
    load_block(60, 0, 0, fc, dr);
    load_block(256, 0, 0, fc, dr);
    chk(!dr, "R7 input side runs during back-pressure", int'(dr), 0);
    chk(lenValid, "R10 length 256 in range", int'(lenValid), 1);
    wait_drained(nQueued);
    stallMode = 0;
    chk(stableBad == 0, "R7 outputs frozen on stall", stableBad, 0);
    chk(blkErr[b] == 0 && blkErr[b+1] == 0, "R7 content under stalls",
        blkErr[b] + blkErr[b+1], 0);
  endtask

  task automatic t_ce_hold();
    int fc; bit dr; int b = nQueued;
    load_block(44, 0, 1, fc, dr);
    wait_drained(nQueued);
    chk(blkErr[b] == 0, "R8 ce low ignores sclr and data", blkErr[b], 0);
  endtask

  task automatic t_clear();
    int fc; bit dr; int b;
    fdIn = 1; nd = 1; blkLen = 40; dataIn = 4'h5;
    @(negedge clk);
    fdIn = 0;
    repeat (10) @(negedge clk);
    nd = 0; sclr = 1;
    @(negedge clk);
    sclr = 0;
    chk(rffd && rfd && !outValid, "R9 clear mid-load", int'({rffd, rfd, outValid}), 6);
    b = nQueued;
    load_block(41, 0, 0, fc, dr);
    wait_drained(nQueued);
    chk(blkErr[b] == 0, "R9 block after clear intact", blkErr[b], 0);
  endtask

  task automatic t_len_check(input int len);
    fdIn = 1; nd = 1; blkLen = LW'(len); dataIn = '0;
    @(negedge clk);
    fdIn = 0; nd = 0;
    chk(!lenValid, $sformatf("R10 length %0d out of range", len), int'(lenValid), 0);
    sclr = 1;
    @(negedge clk);
    sclr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_gaps();
    t_back_to_back();
    t_backpressure();
    t_ce_hold();
    t_clear();
    t_len_check(39);
    t_len_check(257);
    repeat (5) @(negedge clk);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    report();
  end

endmodule